// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block is the digital supervisor of a step-down regulator. Once the supply monitor reports that the chip supply is valid, it moves the converter through a fixed order of phases. First it waits for the supply to settle. During that wait it keeps the low-side gate driver off so that an external sampler can measure the overcurrent threshold on the shared pin. A short initialization gap follows. Then comes the soft-start ramp, with the error amplifier running. Regulation starts after the ramp.

Undervoltage protection is armed only once regulation begins. The power-good output may assert only in that phase, and only while the window comparator reports the output in range. An overvoltage seen in any active phase latches a fault, and the low-side driver is then pulsed to pull the output down. An undervoltage seen while protection is armed latches the converter off. Both faults hold until the supply-valid flag drops. An external enable held low keeps the ramp from starting, so the ramp can wait for a late input supply.

Every duration is a parameter counted in ticks. A tick is a fixed number of clock cycles, and the tick prescaler restarts at the start of each timed phase. As a result, each timed phase lasts exactly its tick count times the tick divider.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, or `por_ok` is low at a clock edge, the outputs after that edge are at rest: `ls_drv_off`=1, and `ls_pulse`, `samp_start`, `ss_en`, `ea_en`, `uv_arm`, `pgood`, `ov_latched`, `uv_latched` all 0.
- R2: Counting the first edge with `por_ok` high as edge 0, `samp_start`=1 and `ls_drv_off`=1 from edge 0. The settle phase ends at edge max(SETTLE_TICKS*TICK_DIV, s), where s is the first edge at which `samp_done` is seen high, and `samp_start` falls at that edge.
- R3: The initialization gap lasts exactly INIT_TICKS*TICK_DIV cycles. During the gap, `ls_drv_off`=1 and `ss_en`=`ea_en`=0.
- R4: The ramp starts only at an edge where `ext_en` is high. If `ext_en` is low when the gap ends, the block waits, and the ramp starts at the first later edge at which `ext_en` is high.
- R5: During the ramp, `ss_en`=`ea_en`=1 and `ls_drv_off`=0. The ramp ends at the first edge at which `ss_done` is high, and regulation begins then.
- R6: `uv_arm` is 1 only in regulation. `uv_arm` is 0 during the ramp and in every earlier phase.
- R7: `pgood` is 0 in every phase except regulation. In regulation, `pgood` after an edge equals `pg_in_win` sampled at that edge.
- R8: With `uv_arm`=1, `uv_det` high at an edge (and no overvoltage) sets `uv_latched`=1 and turns the converter off: `ls_drv_off`=1, `ss_en`=`ea_en`=`uv_arm`=`pgood`=0. `uv_det` has no effect during the ramp.
- R9: `ov_det` high at an edge in any phase from settle through regulation sets `ov_latched`=1 and `ls_drv_off`=0. `ls_pulse` is 1 for the first PULSE_HALF cycles and then toggles every PULSE_HALF cycles. Overvoltage wins over undervoltage at the same edge.
- R10: A latched fault stays latched whatever the comparator and enable inputs do, for as long as `por_ok` is high. The edge after `por_ok` goes low clears both latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Chip supply above power-on threshold |
| samp_done | input | 1 | Overcurrent threshold sampling finished |
| ss_done | input | 1 | Soft-start reference reached final value |
| ext_en | input | 1 | External enable; low delays the ramp |
| pg_in_win | input | 1 | Output inside power-good window |
| ov_det | input | 1 | Overvoltage comparator |
| uv_det | input | 1 | Undervoltage comparator |
| ls_drv_off | output | 1 | Low-side gate driver disabled |
| ls_pulse | output | 1 | Low-side pull-down pulse during overvoltage |
| samp_start | output | 1 | Overcurrent threshold sampler active |
| ss_en | output | 1 | Soft-start ramp and reference enabled |
| ea_en | output | 1 | Error amplifier enabled |
| uv_arm | output | 1 | Undervoltage protection armed |
| pgood | output | 1 | Power-good output |
| ov_latched | output | 1 | Overvoltage fault latched |
| uv_latched | output | 1 | Undervoltage fault latched |

## Verification
The assertions check several rules on every cycle. The settle phase is never left before sampling is done. A ramp never starts without the enable. Power-good never asserts without a window hit on the previous edge. An armed undervoltage always latches. The latches hold, and they clear when the supply flag drops. The exact phase lengths can be shown only by the bench's sweeps. These sweeps cover late sampling, a late enable, the pulse cadence of the overvoltage driver, and ignored undervoltage during the ramp, each checked cycle by cycle against arithmetic edge counts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_INIT,
    ST_HOLD,
    ST_RAMP,
    ST_RUN,
    ST_OVF,
    ST_UVF
  } seq_state_t;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] tcnt;
  logic             tick;

  assign tick = (pre == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre  <= '0;
      tcnt <= '0;
    end else begin
      if (tick) pre <= '0;
      else      pre <= pre + PRE_W'(1);
      if (tick && (tcnt != target)) tcnt <= tcnt + CNT_W'(1);
    end
  end

  // expired, or expiring on this very tick
  assign done = (tcnt == target) || (tick && (tcnt == target - CNT_W'(1)));

  // R2
  tick_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (tcnt <= target));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_TICKS = 4000,
  parameter int INIT_TICKS   = 800,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_ok,
  input  logic             samp_done,
  input  logic             ss_done,
  input  logic             ext_en,
  input  logic             ov_det,
  input  logic             uv_det,
  input  logic             tmr_done,
  output seq_state_t       state_q,
  output seq_state_t       nxt,
  output logic             tmr_clear,
  output logic [CNT_W-1:0] tmr_target
);
  always_comb begin
    nxt = state_q;
    if (!por_ok) begin
      nxt = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    nxt = ST_SETTLE;
        ST_SETTLE: if (ov_det) nxt = ST_OVF;
                   else if (tmr_done && samp_done) nxt = ST_INIT;
        ST_INIT:   if (ov_det) nxt = ST_OVF;
                   else if (tmr_done) nxt = ext_en ? ST_RAMP : ST_HOLD;
        ST_HOLD:   if (ov_det) nxt = ST_OVF;
                   else if (ext_en) nxt = ST_RAMP;
        ST_RAMP:   if (ov_det) nxt = ST_OVF;
                   else if (ss_done) nxt = ST_RUN;
        ST_RUN:    if (ov_det) nxt = ST_OVF;
                   else if (uv_det) nxt = ST_UVF;
        ST_OVF:    nxt = ST_OVF;
        ST_UVF:    nxt = ST_UVF;
        default:   nxt = ST_OFF;
      endcase
    end
  end

  assign tmr_clear  = (nxt != state_q);
  assign tmr_target = (state_q == ST_INIT) ? CNT_W'(INIT_TICKS) : CNT_W'(SETTLE_TICKS);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= nxt;
  end

  // R4
  hold_until_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && por_ok && !ext_en && !ov_det) |=> (state_q == ST_HOLD));

  // R8
  uv_ignored_in_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RAMP && por_ok && !ov_det && !ss_done) |=> (state_q == ST_RAMP));
endmodule

// File: rtl/pwr_seq_outreg.sv
module pwr_seq_outreg
  import pwr_seq_pkg::*;
#(
  parameter int PULSE_HALF = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_q,
  input  seq_state_t nxt,
  input  logic       pg_in_win,
  output logic       ls_drv_off,
  output logic       ls_pulse,
  output logic       samp_start,
  output logic       ss_en,
  output logic       ea_en,
  output logic       uv_arm,
  output logic       pgood,
  output logic       ov_latched,
  output logic       uv_latched
);
  localparam int PC_W = (PULSE_HALF > 1) ? $clog2(PULSE_HALF) : 1;

  logic [PC_W-1:0] pc;
  logic            active;

  assign active = (nxt == ST_RAMP) || (nxt == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_drv_off <= 1'b1;
      samp_start <= 1'b0;
      ss_en      <= 1'b0;
      ea_en      <= 1'b0;
      uv_arm     <= 1'b0;
      pgood      <= 1'b0;
      ov_latched <= 1'b0;
      uv_latched <= 1'b0;
    end else begin
      ls_drv_off <= !(active || (nxt == ST_OVF));
      samp_start <= (nxt == ST_SETTLE);
      ss_en      <= active;
      ea_en      <= active;
      uv_arm     <= (nxt == ST_RUN);
      pgood      <= (nxt == ST_RUN) && pg_in_win;
      ov_latched <= (nxt == ST_OVF);
      uv_latched <= (nxt == ST_UVF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (nxt != ST_OVF)) begin
      ls_pulse <= 1'b0;
      pc       <= '0;
    end else if (state_q != ST_OVF) begin
      ls_pulse <= 1'b1;
      pc       <= '0;
    end else if (pc == PC_W'(PULSE_HALF - 1)) begin
      ls_pulse <= ~ls_pulse;
      pc       <= '0;
    end else begin
      pc <= pc + PC_W'(1);
    end
  end

  // R9
  pulse_starts_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_latched) |-> ls_pulse);

  // R7
  pgood_window_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> ($past(pg_in_win) && uv_arm));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int TICK_DIV     = 4,
  parameter int SETTLE_TICKS = 4000,
  parameter int INIT_TICKS   = 800,
  parameter int PULSE_HALF   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic por_ok,
  input  logic samp_done,
  input  logic ss_done,
  input  logic ext_en,
  input  logic pg_in_win,
  input  logic ov_det,
  input  logic uv_det,
  output logic ls_drv_off,
  output logic ls_pulse,
  output logic samp_start,
  output logic ss_en,
  output logic ea_en,
  output logic uv_arm,
  output logic pgood,
  output logic ov_latched,
  output logic uv_latched
);
  localparam int MAX_TICKS = (SETTLE_TICKS > INIT_TICKS) ? SETTLE_TICKS : INIT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  seq_state_t       state_q;
  seq_state_t       nxt;
  logic             tmr_clear;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_target;

  pwr_seq_timer #(
    .TICK_DIV (TICK_DIV),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (tmr_clear),
    .target (tmr_target),
    .done   (tmr_done)
  );

  pwr_seq_fsm #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .INIT_TICKS   (INIT_TICKS),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .por_ok     (por_ok),
    .samp_done  (samp_done),
    .ss_done    (ss_done),
    .ext_en     (ext_en),
    .ov_det     (ov_det),
    .uv_det     (uv_det),
    .tmr_done   (tmr_done),
    .state_q    (state_q),
    .nxt        (nxt),
    .tmr_clear  (tmr_clear),
    .tmr_target (tmr_target)
  );

  pwr_seq_outreg #(
    .PULSE_HALF (PULSE_HALF)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .nxt        (nxt),
    .pg_in_win  (pg_in_win),
    .ls_drv_off (ls_drv_off),
    .ls_pulse   (ls_pulse),
    .samp_start (samp_start),
    .ss_en      (ss_en),
    .ea_en      (ea_en),
    .uv_arm     (uv_arm),
    .pgood      (pgood),
    .ov_latched (ov_latched),
    .uv_latched (uv_latched)
  );

  // R2
  settle_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(samp_start) && $past(por_ok) && !ov_latched) |-> $past(samp_done));

  // R4
  ramp_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_en) |-> $past(ext_en));

  // R8
  uv_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_arm && uv_det && por_ok && !ov_det) |=> uv_latched);

  // R10
  ov_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_latched && por_ok) |=> ov_latched);

  // R10
  uv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_latched && por_ok) |=> uv_latched);

  // R10
  por_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !por_ok |=> (!ov_latched && !uv_latched && !pgood && ls_drv_off));
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int TD = 2;
  localparam int ST = 3;
  localparam int IT = 2;
  localparam int PH = 3;
  localparam int SET_CYC  = ST * TD;
  localparam int INIT_CYC = IT * TD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_ok = 1'b0, samp_done = 1'b0, ss_done = 1'b0, ext_en = 1'b0;
  logic pg_in_win = 1'b0, ov_det = 1'b0, uv_det = 1'b0;
  logic ls_drv_off, ls_pulse, samp_start, ss_en, ea_en, uv_arm, pgood, ov_latched, uv_latched;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(
    .TICK_DIV (TD), .SETTLE_TICKS (ST), .INIT_TICKS (IT), .PULSE_HALF (PH)
  ) uut (
    .clk (clk), .rst (rst), .por_ok (por_ok), .samp_done (samp_done),
    .ss_done (ss_done), .ext_en (ext_en), .pg_in_win (pg_in_win),
    .ov_det (ov_det), .uv_det (uv_det), .ls_drv_off (ls_drv_off),
    .ls_pulse (ls_pulse), .samp_start (samp_start), .ss_en (ss_en),
    .ea_en (ea_en), .uv_arm (uv_arm), .pgood (pgood),
    .ov_latched (ov_latched), .uv_latched (uv_latched)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_rest(string req);
    chk(req, "ls_drv_off", ls_drv_off, 1'b1);
    chk(req, "ls_pulse", ls_pulse, 1'b0);
    chk(req, "samp_start", samp_start, 1'b0);
    chk(req, "ss_en", ss_en, 1'b0);
    chk(req, "ea_en", ea_en, 1'b0);
    chk(req, "uv_arm", uv_arm, 1'b0);
    chk(req, "pgood", pgood, 1'b0);
    chk(req, "ov_latched", ov_latched, 1'b0);
    chk(req, "uv_latched", uv_latched, 1'b0);
  endtask

  task automatic power_down();
    por_ok = 1'b0; samp_done = 1'b0; ss_done = 1'b0; ext_en = 1'b0;
    pg_in_win = 1'b0; ov_det = 1'b0; uv_det = 1'b0;
    step(1);
    chk_rest("R10 por drop");
  endtask

  // s, h: first edge (edge 0 = first edge with por_ok) where samp_done / ext_en are high
  task automatic run_start(int s, int h);
    int ex1, rmp;
    ex1 = (s > SET_CYC) ? s : SET_CYC;
    rmp = (h > ex1 + INIT_CYC) ? h : ex1 + INIT_CYC;
    por_ok = 1'b1;
    samp_done = (s <= 0);
    ext_en = (h <= 0);
    for (int j = 0; j <= rmp; j++) begin
      step(1);
      chk("R2", "samp_start", samp_start, (j < ex1));
      chk("R3", "ls_drv_off", ls_drv_off, (j < rmp));
      chk("R3", "ea_en", ea_en, (j >= rmp));
      chk("R4", "ss_en", ss_en, (j >= rmp));
      chk("R6", "uv_arm", uv_arm, 1'b0);
      if (j + 1 >= s) samp_done = 1'b1;
      if (j + 1 >= h) ext_en = 1'b1;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL R1 watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    por_ok = 1'b1;
    step(3);
    chk_rest("R1 reset");
    rst = 1'b0; por_ok = 1'b0;
    step(2);
    chk_rest("R1 por low");

    // R2 R3 R4: sweep late sampling and late enable
    for (int s = 0; s <= 9; s++) begin
      for (int hi = 0; hi < 4; hi++) begin
        int h;
        h = (hi == 0) ? 0 : (hi == 1) ? 8 : (hi == 2) ? 12 : 15;
        run_start(s, h);
        power_down();
      end
    end

    // R5 R6 R7 R8: ramp ignores uv and pg, regulation follows window
    run_start(0, 0);
    pg_in_win = 1'b1; uv_det = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R5", "ss_en", ss_en, 1'b1);
      chk("R5", "ls_drv_off", ls_drv_off, 1'b0);
      chk("R6", "uv_arm", uv_arm, 1'b0);
      chk("R7", "pgood", pgood, 1'b0);
      chk("R8", "uv_latched", uv_latched, 1'b0);
    end
    uv_det = 1'b0; ss_done = 1'b1;
    step(1);
    chk("R6", "uv_arm", uv_arm, 1'b1);
    chk("R7", "pgood", pgood, 1'b1);
    chk("R5", "ea_en", ea_en, 1'b1);
    ss_done = 1'b0;
    pat = 16'hB3C5;
    for (int k = 0; k < 16; k++) begin
      pg_in_win = pat[k];
      step(1);
      chk("R7", "pgood", pgood, pat[k]);
    end
    uv_det = 1'b1;
    step(1);
    chk("R8", "uv_latched", uv_latched, 1'b1);
    chk("R8", "ls_drv_off", ls_drv_off, 1'b1);
    chk("R8", "ss_en", ss_en, 1'b0);
    chk("R8", "ea_en", ea_en, 1'b0);
    chk("R8", "uv_arm", uv_arm, 1'b0);
    chk("R8", "pgood", pgood, 1'b0);
    uv_det = 1'b0; ov_det = 1'b1; pg_in_win = 1'b1; ss_done = 1'b1;
    step(3);
    chk("R10", "uv_latched", uv_latched, 1'b1);
    chk("R10", "ov_latched", ov_latched, 1'b0);
    chk("R10", "pgood", pgood, 1'b0);
    power_down();

    // R9: overvoltage during settle, pulse cadence
    por_ok = 1'b1;
    step(2);
    ov_det = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(1);
      chk("R9", "ls_pulse", ls_pulse, ((k / PH) % 2) == 0);
      chk("R9", "ov_latched", ov_latched, 1'b1);
      chk("R9", "ls_drv_off", ls_drv_off, 1'b0);
      ov_det = 1'b0; samp_done = 1'b1; ext_en = 1'b1; ss_done = 1'b1;
    end
    chk("R10", "ss_en", ss_en, 1'b0);
    power_down();

    // R9: overvoltage wins over undervoltage in regulation
    run_start(0, 0);
    ss_done = 1'b1;
    step(1);
    ss_done = 1'b0; ov_det = 1'b1; uv_det = 1'b1;
    step(1);
    chk("R9", "ov_latched", ov_latched, 1'b1);
    chk("R9", "uv_latched", uv_latched, 1'b0);
    power_down();

    // R1: synchronous reset in mid-ramp
    run_start(0, 0);
    rst = 1'b1;
    step(1);
    chk_rest("R1 mid reset");
    rst = 1'b0;
    power_down();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule